// File: doc/BRIEF.md
# Receive Word Queue with Overrun Lockout

This block sits between a serial receiver's shift stage and the reader of received characters. Each time the receiver finishes a character, it presents a data word and two error indications: a bad stop level (framing) and a parity mismatch. The block queues up to four such words in arrival order. The oldest word is always visible on the head outputs together with its own two error bits, so a reader can judge a word before it removes it.

When all four slots are occupied and the receiver completes one more word, the block does not discard anything. It raises a sticky overrun flag, latches that extra word into a separate holding register with its flags, and refuses every later write. Reads continue to work, so the reader can drain the four queued words and inspect the held one. A software clear of the overrun flag then empties the queue completely and restarts normal operation.

Top module: `rxq_lockout_fifo`

## Requirements
- R1: After reset, `data_avail` is 0 and `ovr_flag` is 0.
- R2: Words written with `wr_valid` while the queue holds fewer than DEPTH (4) entries and `ovr_flag` is 0 leave on `head_data` in arrival order. A write and a pop may happen in the same cycle.
- R3: `head_ferr` and `head_perr` show the framing and parity bits that were written together with the word on `head_data`.
- R4: `data_avail` is 1 in every cycle that the queue holds at least one entry and 0 otherwise. The effect of a write or pop appears in the cycle after the clock edge that samples it.
- R5: A pop (`rd_pop`=1) while the queue is empty has no effect. `data_avail` stays 0, and a later write is still returned correctly.
- R6: A write that arrives while the queue already holds 4 entries at the start of the cycle (and `ovr_flag` is 0) sets `ovr_flag` after that edge. It places the word and its flags on `hold_data`/`hold_ferr`/`hold_perr` and leaves the queued words unchanged.
- R7: While `ovr_flag` is 1, `wr_valid` is ignored. The queue contents and the hold outputs do not change, and the flag stays 1 until cleared.
- R8: While `ovr_flag` is 1, pops still remove the head word in order. This allows all four stored words to be drained.
- R9: `ovr_clear`=1 empties the queue and clears `ovr_flag`. After that edge, `data_avail` and `ovr_flag` are both 0, and any pop in the same cycle is absorbed.
- R10: If `ovr_clear` and `wr_valid` are both 1 in one cycle, the clear takes effect and the word is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Receiver has completed one word this cycle |
| wr_data | input | DATA_W (9) | Completed word |
| wr_ferr | input | 1 | Framing error of the completed word |
| wr_perr | input | 1 | Parity error of the completed word |
| rd_pop | input | 1 | Remove the head word |
| ovr_clear | input | 1 | Clear overrun and flush the queue |
| head_data | output | DATA_W (9) | Oldest queued word |
| head_ferr | output | 1 | Framing error of the oldest word |
| head_perr | output | 1 | Parity error of the oldest word |
| data_avail | output | 1 | Queue holds at least one word |
| ovr_flag | output | 1 | Sticky overrun indication |
| hold_data | output | DATA_W (9) | Word that caused the overrun |
| hold_ferr | output | 1 | Framing error of the held word |
| hold_perr | output | 1 | Parity error of the held word |

## Verification
The assertions check the following on every cycle: the flush after a clear, that the overrun flag is sticky, that the hold outputs stay frozen during overrun, that overrun can only begin from a write into a non-empty queue, and that an accepted write makes data available. Some properties depend on how many words the queue holds, which is not visible at the ports. These are shown by the bench's reference queue. They include arrival order, the pairing of each word with its error bits, overrun firing exactly on the fifth word, and the drain of all four words during overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Number of per-word error bits stored next to the data: framing, parity.
   localparam int unsigned FLAG_BITS = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             rd_pop,
   input  logic             ovr_clear,
   output logic             push,
   output logic             capture,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             not_empty,
   output logic             ovr
);
   logic [CNT_W-1:0] count;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic             accept, full, pop;

   assign full      = (count == CNT_W'(DEPTH));
   assign not_empty = (count != '0);
   assign accept    = wr_valid && !ovr && !ovr_clear;
   assign push      = accept && !full;
   assign capture   = accept && full;
   assign pop       = rd_pop && not_empty && !ovr_clear;

   generate
      if (rxq_pkg::is_pow2(DEPTH)) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr    <= 1'b0;
      end else if (ovr_clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr    <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
         if (capture) ovr <= 1'b1;
      end
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned ENT_W = 11,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [ENT_W-1:0] wr_ent,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [ENT_W-1:0] head_ent
);
   logic [ENT_W-1:0] slot [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[g] <= '0;
            else if (we && (wr_ptr == PTR_W'(g)))
               slot[g] <= wr_ent;
         end
      end
   endgenerate

   assign head_ent = slot[rd_ptr];
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
   parameter int unsigned ENT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ENT_W-1:0] din,
   output logic [ENT_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/rxq_lockout_fifo.sv
module rxq_lockout_fifo #(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ferr,
   input  logic              wr_perr,
   input  logic              rd_pop,
   input  logic              ovr_clear,
   output logic [DATA_W-1:0] head_data,
   output logic              head_ferr,
   output logic              head_perr,
   output logic              data_avail,
   output logic              ovr_flag,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_ferr,
   output logic              hold_perr
);
   localparam int unsigned ENT_W = DATA_W + rxq_pkg::FLAG_BITS;
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("rxq_lockout_fifo: DATA_W out of range");
      end
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("rxq_lockout_fifo: DEPTH out of range");
      end
   endgenerate

   logic             push, capture;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [ENT_W-1:0] in_ent, head_ent, hold_ent;

   // Entry layout: {framing, parity, data}
   assign in_ent = {wr_ferr, wr_perr, wr_data};

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .rd_pop    (rd_pop),
      .ovr_clear (ovr_clear),
      .push      (push),
      .capture   (capture),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .not_empty (data_avail),
      .ovr       (ovr_flag)
   );

   rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (push),
      .wr_ptr   (wr_ptr),
      .wr_ent   (in_ent),
      .rd_ptr   (rd_ptr),
      .head_ent (head_ent)
   );

   rxq_hold #(.ENT_W(ENT_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (capture),
      .din   (in_ent),
      .dout  (hold_ent)
   );

   assign {head_ferr, head_perr, head_data} = head_ent;
   assign {hold_ferr, hold_perr, hold_data} = hold_ent;
endmodule

// File: rtl/rxq_lockout_fifo_chk.sv
module rxq_lockout_fifo_chk #(
   parameter int unsigned DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              rd_pop,
   input logic              ovr_clear,
   input logic              data_avail,
   input logic              ovr_flag,
   input logic [DATA_W-1:0] hold_data,
   input logic              hold_ferr,
   input logic              hold_perr
);
   // R9
   clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_clear |=> (!ovr_flag && !data_avail));

   // R7
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clear) |=> ovr_flag);

   // R7
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clear) |=>
         ($stable(hold_data) && $stable(hold_ferr) && $stable(hold_perr)));

   // R6
   ovr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> ($past(wr_valid) && $past(data_avail) && !$past(ovr_clear)));

   // R4
   write_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !ovr_flag && !ovr_clear) |=> data_avail);

   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_avail && rd_pop && !wr_valid) |=> !data_avail);
endmodule

bind rxq_lockout_fifo rxq_lockout_fifo_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .rd_pop     (rd_pop),
   .ovr_clear  (ovr_clear),
   .data_avail (data_avail),
   .ovr_flag   (ovr_flag),
   .hold_data  (hold_data),
   .hold_ferr  (hold_ferr),
   .hold_perr  (hold_perr)
);

// File: tb/rxq_lockout_fifo_tb.sv
`timescale 1ns/1ps
module rxq_lockout_fifo_tb;
   localparam int DW = 9;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_ferr = 1'b0, wr_perr = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_pop = 1'b0, ovr_clear = 1'b0;
   logic [DW-1:0] head_data, hold_data;
   logic          head_ferr, head_perr, data_avail, ovr_flag, hold_ferr, hold_perr;

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   // model state: entries {ferr, perr, data}
   logic [DW+1:0] mq[$];
   bit            m_ovr = 0;
   logic [DW+1:0] m_hold = '0;

   always #2 clk = ~clk;

   rxq_lockout_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ferr(wr_ferr), .wr_perr(wr_perr), .rd_pop(rd_pop), .ovr_clear(ovr_clear),
      .head_data(head_data), .head_ferr(head_ferr), .head_perr(head_perr),
      .data_avail(data_avail), .ovr_flag(ovr_flag), .hold_data(hold_data),
      .hold_ferr(hold_ferr), .hold_perr(hold_perr));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R4 data_avail", 32'(data_avail), 32'(mq.size() > 0));
      chk("R6 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
      if (mq.size() > 0) begin
         chk("R2 head_data", 32'(head_data), 32'(mq[0][DW-1:0]));
         chk("R3 head flags", 32'({head_ferr, head_perr}), 32'(mq[0][DW+1:DW]));
      end
      if (m_ovr)
         chk("R7 hold word", 32'({hold_ferr, hold_perr, hold_data}), 32'(m_hold));
   endtask

   // drive one cycle, update model at the edge, compare at the falling edge
   task automatic step(input bit wr, input int d, input bit fe, input bit pe,
                       input bit pop, input bit clr);
      logic [DW+1:0] w;
      wr_valid = wr; wr_data = DW'(d); wr_ferr = fe; wr_perr = pe;
      rd_pop = pop; ovr_clear = clr;
      w = {fe, pe, DW'(d)};
      @(posedge clk);
      if (clr) begin
         mq.delete();
         m_ovr = 0;
      end else begin
         bit full = (mq.size() == DEPTH);
         bit popq = pop && (mq.size() > 0);
         if (popq) void'(mq.pop_front());
         if (wr && !m_ovr) begin
            if (full) begin m_ovr = 1; m_hold = w; end
            else mq.push_back(w);
         end
      end
      @(negedge clk);
      wr_valid = 0; rd_pop = 0; ovr_clear = 0;
      compare_all();
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 avail at reset", 32'(data_avail), 0);
      chk("R1 ovr at reset", 32'(ovr_flag), 0);
      rst_n = 1;
      idle();

      // R5 pop on empty
      step(0, 0, 0, 0, 1, 0);
      chk("R5 empty pop keeps empty", 32'(data_avail), 0);
      step(1, 9'h1A5, 0, 1, 0, 0);
      chk("R5 write after empty pop", 32'(head_data), 32'h1A5);
      step(0, 0, 0, 0, 1, 0);

      // R2 R3 ordering with flags, simultaneous push/pop
      step(1, 9'h001, 1, 0, 0, 0);
      step(1, 9'h0FE, 0, 1, 0, 0);
      step(1, 9'h155, 1, 1, 1, 0);
      chk("R3 head flags after push+pop", 32'({head_ferr, head_perr}), 32'b01);
      step(0, 0, 0, 0, 1, 0);
      chk("R2 third word at head", 32'(head_data), 32'h155);
      step(0, 0, 0, 0, 1, 0);
      chk("R4 empty after drain", 32'(data_avail), 0);

      // R6 fill and overrun on the fifth word
      for (int i = 0; i < DEPTH; i++) step(1, 9'h100 + i, i[0], i[1], 0, 0);
      chk("R6 no overrun at four", 32'(ovr_flag), 0);
      step(1, 9'h0C3, 1, 0, 0, 0);
      chk("R6 overrun on fifth", 32'(ovr_flag), 1);
      chk("R6 held word", 32'({hold_ferr, hold_perr, hold_data}), 32'({2'b10, 9'h0C3}));
      chk("R6 head unchanged", 32'(head_data), 32'h100);

      // R7 writes ignored during overrun
      step(1, 9'h077, 0, 1, 0, 0);
      chk("R7 hold kept", 32'(hold_data), 32'h0C3);
      chk("R7 flag sticky", 32'(ovr_flag), 1);

      // R8 drain during overrun
      for (int i = 0; i < DEPTH; i++) begin
         chk("R8 drain order", 32'(head_data), 32'h100 + 32'(i));
         step(0, 0, 0, 0, 1, 0);
      end
      chk("R8 drained", 32'(data_avail), 0);

      // R9 clear
      step(0, 0, 0, 0, 0, 1);
      chk("R9 flag cleared", 32'(ovr_flag), 0);
      step(1, 9'h033, 0, 0, 0, 0);
      chk("R9 writes accepted again", 32'(head_data), 32'h033);

      // R9 clear flushes stored words, pop absorbed
      step(1, 9'h034, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1);
      chk("R9 flush", 32'(data_avail), 0);

      // R10 clear beats write
      step(1, 9'h011, 0, 0, 0, 0);
      step(1, 9'h022, 1, 1, 0, 1);
      chk("R10 write dropped on clear", 32'(data_avail), 0);
      step(1, 9'h044, 0, 0, 0, 0);
      chk("R10 next write at head", 32'(head_data), 32'h044);

      // overrun then clear without draining
      for (int i = 0; i < DEPTH + 1; i++) step(1, 9'h0A0 + i, 0, 0, 0, 0);
      chk("R6 overrun from partial start", 32'(ovr_flag), 1);
      step(1, 9'h0EE, 0, 0, 0, 1);
      chk("R10 clear during overrun drops write", 32'(data_avail), 0);
      repeat (3) idle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule